// File: doc/BRIEF.md
# Split Register File with Interrupt

This block is the byte-wide host register interface of a small bus-controller core. Sixteen register offsets are visible to the host. Reading and writing the same offset can reach two different registers, so the block keeps two banks: a readable bank and a write bank. Some writes are also copied into the readable bank, so software can read back configuration. Others stay in the write bank only, where the command engine picks them up.

The interrupt line is held as the top bit of the status register. The command engine outside this block sets it through a raise request and can set other status bits through a set mask. The host clears it by reading the interrupt-reason register. That read also wipes the two error flags. Side effects happen only on the first cycle of a read strobe, so a stalled bus that holds the strobe applies them once.

The register offset is the byte address shifted right by a stride parameter, so the block can sit on a bus with word-spaced registers. Command writes are passed to the engine through a strobe and a code byte. A command with its top bit set reloads the readable transfer-count bytes.

Top module: `hreg_split_top`

## Requirements
- R1: The register offset is `bus_addr >> STRIDE` (4 bits). The low STRIDE address bits are ignored for both reads and writes.
- R2: After reset, every readable offset reads 0x00 except offset 14 (reads 0x04) and offset 8 (reads 0x07). The write bank is all zero and `irq_line` is low.
- R3: `bus_rdata` always shows the readable bank at the addressed offset. A write to offset 3, 8, 11, 12, 13, 14 or 15 updates both banks. A write to offset 0, 1, 2, 4, 5, 6, 7, 9 or 10 updates the write bank only, which is visible on `wr_regs` at bits [8*k+7:8*k].
- R4: A write to offset 3 whose bit 7 is 1 copies the write-bank bytes at offsets 0 and 1 into readable offsets 0 and 1 on the same edge. If bit 7 is 0, readable offsets 0 and 1 are unchanged.
- R5: A write to offset 0 or 1 clears status (readable offset 4) bit 4.
- R6: `irq_raise` sets status bit 7 on the next edge. `irq_line` equals status bit 7. A raise while the bit is already set leaves it set.
- R7: A read of offset 5 clears status bits 7, 6 and 5 on the next edge, dropping `irq_line`. Reads of any other offset have no side effect.
- R8: The read side effect acts only on the first cycle of a read strobe. Holding `bus_rd` for further cycles applies nothing more.
- R9: In one cycle, clears are applied before sets. `irq_raise` and `stat_set` win over the offset-5 read clear and the offset-0/1 write clear.
- R10: `stat_set[k]` (k = 0..6) sets status bit k on the next edge. No other status bit changes.
- R11: `cmd_fire` is 1 in the same cycle as a write to offset 3, and `cmd_code` then carries the written byte. `cmd_fire` is 0 for writes elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | STRIDE+4 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Readable bank at the addressed offset |
| irq_raise | input | 1 | Interrupt raise request from the command engine |
| stat_set | input | 7 | Status bits 6..0 set request from the command engine |
| cmd_fire | output | 1 | Command byte written this cycle |
| cmd_code | output | 8 | Command byte |
| wr_regs | output | 128 | Write bank, offset k in bits [8k+7:8k] |
| irq_line | output | 1 | Level interrupt, equal to status bit 7 |

## Verification
The bench checks every offset against its bank routing. A design that mirrored a write-only offset into the readable bank would return the written value instead of 0x00. Same-cycle races are covered: a raise together with a reason read, and a status set together with a transfer-count write. A design that applied the clears after the sets would lose the interrupt or the terminal-count flag. A reason read held for three cycles, with a raise in its second cycle, catches a level-sensitive side effect, which would drop the interrupt again. The stride decode is checked with junk in the low address bits. The transfer-count reload is checked from both the command path and a fresh reset, which exposes a write bank that reset does not clear.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int REG_IDX_W = 4;
    localparam int NUM_REGS  = 1 << REG_IDX_W;
    localparam int BYTE_W    = 8;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;
    typedef logic [BYTE_W-1:0]    byte_t;

    localparam reg_idx_t OFS_CNT_LO  = 4'd0;
    localparam reg_idx_t OFS_CNT_MID = 4'd1;
    localparam reg_idx_t OFS_CMD     = 4'd3;
    localparam reg_idx_t OFS_STATUS  = 4'd4;
    localparam reg_idx_t OFS_REASON  = 4'd5;
    localparam reg_idx_t OFS_CFG_A   = 4'd8;
    localparam reg_idx_t OFS_VARIANT = 4'd14;

    localparam int ST_IRQ    = 7;
    localparam int ST_GROSS  = 6;
    localparam int ST_PARITY = 5;
    localparam int ST_TCOUNT = 4;
    localparam int CMD_RELOAD_BIT = 7;

    localparam byte_t RST_CFG_A   = 8'h07;
    localparam byte_t RST_VARIANT = 8'h04;

    typedef struct packed {
        logic     wr;
        logic     rd_first;
        reg_idx_t idx;
        byte_t    data;
    } bus_op_t;

    function automatic logic is_mirrored(reg_idx_t i);
        return (i == OFS_CMD) || (i == OFS_CFG_A) || (i >= 4'd11);
    endfunction

    function automatic byte_t reset_value(reg_idx_t i);
        if (i == OFS_VARIANT) return RST_VARIANT;
        if (i == OFS_CFG_A)   return RST_CFG_A;
        return '0;
    endfunction

endpackage

// File: rtl/hreg_decode.sv
module hreg_decode
    import hreg_pkg::*;
#(
    parameter int STRIDE = 2,
    parameter int ADDR_W = REG_IDX_W + STRIDE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output bus_op_t           op
);

    logic rd_q;

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= bus_rd;
    end

    // R1: offset from the shifted byte address
    // R8: side effects only on the first strobe cycle
    always_comb begin
        op.wr       = bus_wr;
        op.rd_first = bus_rd & ~rd_q;
        op.idx      = reg_idx_t'(bus_addr >> STRIDE);
        op.data     = bus_wdata;
    end

endmodule

// File: rtl/hreg_write_bank.sv
module hreg_write_bank
    import hreg_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  bus_op_t                op,
    output byte_t [NUM_REGS-1:0]   wbank
);

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_wreg
        always_ff @(posedge clk) begin
            if (rst)
                wbank[k] <= '0;
            else if (op.wr && op.idx == reg_idx_t'(k))
                wbank[k] <= op.data;
        end
    end

endmodule

// File: rtl/hreg_read_bank.sv
module hreg_read_bank
    import hreg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_op_t              op,
    input  byte_t                cnt_lo_w,
    input  byte_t                cnt_mid_w,
    input  logic                 irq_raise,
    input  logic [6:0]           stat_set,
    output byte_t [NUM_REGS-1:0] rbank,
    output logic                 irq
);

    byte_t [NUM_REGS-1:0] nxt;

    always_comb begin
        nxt = rbank;
        if (op.wr) begin
            if (is_mirrored(op.idx))
                nxt[op.idx] = op.data;
            if (op.idx == OFS_CMD && op.data[CMD_RELOAD_BIT]) begin
                nxt[OFS_CNT_LO]  = cnt_lo_w;
                nxt[OFS_CNT_MID] = cnt_mid_w;
            end
            if (op.idx == OFS_CNT_LO || op.idx == OFS_CNT_MID)
                nxt[OFS_STATUS][ST_TCOUNT] = 1'b0;
        end
        if (op.rd_first && op.idx == OFS_REASON) begin
            nxt[OFS_STATUS][ST_IRQ]    = 1'b0;
            nxt[OFS_STATUS][ST_GROSS]  = 1'b0;
            nxt[OFS_STATUS][ST_PARITY] = 1'b0;
        end
        // sets after clears (R9)
        nxt[OFS_STATUS][6:0] = nxt[OFS_STATUS][6:0] | stat_set;
        if (irq_raise)
            nxt[OFS_STATUS][ST_IRQ] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++)
                rbank[i] <= reset_value(reg_idx_t'(i));
        end else begin
            rbank <= nxt;
        end
    end

    assign irq = rbank[OFS_STATUS][ST_IRQ];

    // R6
    raise_sets_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_raise |=> irq);

    // R6
    no_spurious_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(irq_raise));

    // R7
    reason_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op.rd_first && op.idx == OFS_REASON && !irq_raise && stat_set[6:5] == 2'b00)
        |=> (!irq && rbank[OFS_STATUS][6:5] == 2'b00));

    // R5
    tcount_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op.wr && (op.idx == OFS_CNT_LO || op.idx == OFS_CNT_MID) && !stat_set[ST_TCOUNT])
        |=> !rbank[OFS_STATUS][ST_TCOUNT]);

endmodule

// File: rtl/hreg_split_top.sv
module hreg_split_top
    import hreg_pkg::*;
#(
    parameter int STRIDE = 2,
    parameter int ADDR_W = REG_IDX_W + STRIDE
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [7:0]                 bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [7:0]                 bus_rdata,
    input  logic                       irq_raise,
    input  logic [6:0]                 stat_set,
    output logic                       cmd_fire,
    output logic [7:0]                 cmd_code,
    output logic [NUM_REGS*BYTE_W-1:0] wr_regs,
    output logic                       irq_line
);

    bus_op_t              op;
    byte_t [NUM_REGS-1:0] wbank;
    byte_t [NUM_REGS-1:0] rbank;

    hreg_decode #(.STRIDE(STRIDE), .ADDR_W(ADDR_W)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .op        (op)
    );

    hreg_write_bank u_wbank (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wbank (wbank)
    );

    hreg_read_bank u_rbank (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .cnt_lo_w  (wbank[OFS_CNT_LO]),
        .cnt_mid_w (wbank[OFS_CNT_MID]),
        .irq_raise (irq_raise),
        .stat_set  (stat_set),
        .rbank     (rbank),
        .irq       (irq_line)
    );

    // R3, R11
    assign bus_rdata = rbank[op.idx];
    assign cmd_fire  = op.wr && (op.idx == OFS_CMD);
    assign cmd_code  = op.data;
    assign wr_regs   = wbank;

    // R4
    count_reload_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && op.idx == OFS_CMD && bus_wdata[CMD_RELOAD_BIT])
        |=> (rbank[OFS_CNT_LO] == $past(wbank[OFS_CNT_LO]) &&
             rbank[OFS_CNT_MID] == $past(wbank[OFS_CNT_MID])));

endmodule

// File: tb/test_hreg_split_top.sv
`timescale 1ns/1ps
module test_hreg_split_top;

    localparam int STRIDE = 2;
    localparam int AW     = STRIDE + 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic          irq_raise = 1'b0;
    logic [6:0]    stat_set = '0;
    logic          cmd_fire;
    logic [7:0]    cmd_code;
    logic [127:0]  wr_regs;
    logic          irq_line;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hreg_split_top #(.STRIDE(STRIDE)) i_hreg_split_top (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_raise(irq_raise), .stat_set(stat_set), .cmd_fire(cmd_fire),
        .cmd_code(cmd_code), .wr_regs(wr_regs), .irq_line(irq_line)
    );

    typedef struct packed {
        logic [1:0] op;     // 0 idle, 1 write, 2 read
        logic [3:0] off;
        logic [7:0] wd;
        logic       rs;
        logic [6:0] st;
        logic [7:0] exp_rd;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VEC [NV] = '{
        '{2'd2, 4'h8, 8'h00, 1'b0, 7'h00, 8'h07, 1'b0, 4'd2},  // R2
        '{2'd2, 4'hE, 8'h00, 1'b0, 7'h00, 8'h04, 1'b0, 4'd2},  // R2
        '{2'd2, 4'h4, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd2},  // R2
        '{2'd2, 4'h5, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd2},  // R2
        '{2'd1, 4'h8, 8'h5A, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h8, 8'h00, 1'b0, 7'h00, 8'h5A, 1'b0, 4'd3},  // R3
        '{2'd1, 4'h4, 8'h33, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h4, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd1, 4'h9, 8'hFF, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h9, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd1, 4'hA, 8'h11, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'hA, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd1, 4'hC, 8'hC3, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'hC, 8'h00, 1'b0, 7'h00, 8'hC3, 1'b0, 4'd3},  // R3
        '{2'd1, 4'h3, 8'h10, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h3, 8'h00, 1'b0, 7'h00, 8'h10, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h0, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd4},  // R4 no reload
        '{2'd1, 4'h0, 8'h34, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd1, 4'h1, 8'h12, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h0, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd1, 4'h3, 8'h90, 1'b0, 7'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{2'd2, 4'h0, 8'h00, 1'b0, 7'h00, 8'h34, 1'b0, 4'd4},  // R4
        '{2'd2, 4'h1, 8'h00, 1'b0, 7'h00, 8'h12, 1'b0, 4'd4},  // R4
        '{2'd2, 4'h3, 8'h00, 1'b0, 7'h00, 8'h90, 1'b0, 4'd3},  // R3
        '{2'd0, 4'h0, 8'h00, 1'b0, 7'h70, 8'h00, 1'b0, 4'd10}, // R10
        '{2'd2, 4'h4, 8'h00, 1'b0, 7'h00, 8'h70, 1'b0, 4'd10}, // R10
        '{2'd1, 4'h1, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd5},  // R5
        '{2'd2, 4'h4, 8'h00, 1'b0, 7'h00, 8'h60, 1'b0, 4'd5},  // R5
        '{2'd0, 4'h0, 8'h00, 1'b1, 7'h00, 8'h00, 1'b1, 4'd6},  // R6
        '{2'd2, 4'h4, 8'h00, 1'b0, 7'h00, 8'hE0, 1'b1, 4'd7},  // R7 status read no effect
        '{2'd2, 4'h5, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd7},  // R7
        '{2'd2, 4'h4, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd7},  // R7
        '{2'd1, 4'hD, 8'h77, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'hD, 8'h00, 1'b0, 7'h00, 8'h77, 1'b0, 4'd3},  // R3
        '{2'd1, 4'hF, 8'h88, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'hF, 8'h00, 1'b0, 7'h00, 8'h88, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h7, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd2, 4'h6, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd3},  // R3
        '{2'd1, 4'h0, 8'hAB, 1'b0, 7'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{2'd1, 4'h3, 8'h81, 1'b0, 7'h00, 8'h00, 1'b0, 4'd4},  // R4
        '{2'd2, 4'h0, 8'h00, 1'b0, 7'h00, 8'hAB, 1'b0, 4'd4},  // R4
        '{2'd2, 4'h1, 8'h00, 1'b0, 7'h00, 8'h00, 1'b0, 4'd4}   // R4
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp_v);
        end
    endtask

    // one access cycle with an idle cycle after; samples before and after the edge
    task automatic cycle(input logic w, input logic r, input logic [3:0] off,
                         input logic [STRIDE-1:0] low, input logic [7:0] wd,
                         input logic rs, input logic [6:0] st,
                         output logic [7:0] rd_seen, output logic irq_seen,
                         output logic fire_seen, output logic [7:0] code_seen);
        @(negedge clk);
        bus_wr = w; bus_rd = r; bus_addr = {off, low}; bus_wdata = wd;
        irq_raise = rs; stat_set = st;
        #2;
        rd_seen = bus_rdata; fire_seen = cmd_fire; code_seen = cmd_code;
        @(posedge clk); #1;
        irq_seen = irq_line;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; irq_raise = 0; stat_set = '0;
    endtask

    task automatic rd_reg(input logic [3:0] off, output logic [7:0] v, output logic irq_v);
        logic f; logic [7:0] c;
        cycle(1'b0, 1'b1, off, '0, 8'h00, 1'b0, 7'h00, v, irq_v, f, c);
    endtask

    task automatic wr_reg(input logic [3:0] off, input logic [7:0] d);
        logic [7:0] v, c; logic q, f;
        cycle(1'b1, 1'b0, off, '0, d, 1'b0, 7'h00, v, q, f, c);
    endtask

    task automatic summary_and_end();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary_and_end();
    end

    initial begin
        logic [7:0] v, c;
        logic q, f;

        repeat (3) @(negedge clk);
        rst = 0;
        check("R2 irq after reset", 128'(irq_line), 128'(0));
        check("R2 write bank after reset", wr_regs, 128'(0));

        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i].op == 2'd1, VEC[i].op == 2'd2, VEC[i].off, '0, VEC[i].wd,
                  VEC[i].rs, VEC[i].st, v, q, f, c);
            if (VEC[i].op == 2'd2)
                check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), 128'(v), 128'(VEC[i].exp_rd));
            check($sformatf("R%0d vec %0d irq", VEC[i].req, i), 128'(q), 128'(VEC[i].exp_irq));
        end

        // R9: raise beats the reason-read clear in the same cycle
        cycle(1'b0, 1'b0, 4'h0, '0, 8'h00, 1'b1, 7'h40, v, q, f, c);
        check("R6 raise with gross error", 128'(q), 128'(1));
        cycle(1'b0, 1'b1, 4'h5, '0, 8'h00, 1'b1, 7'h00, v, q, f, c);
        check("R9 raise wins over reason read", 128'(q), 128'(1));
        rd_reg(4'h4, v, q);
        check("R9 status after race", 128'(v), 128'(8'h80));
        rd_reg(4'h5, v, q);
        check("R7 reason read drops irq", 128'(q), 128'(0));

        // R8: held read strobe applies its side effect once
        cycle(1'b0, 1'b0, 4'h0, '0, 8'h00, 1'b1, 7'h00, v, q, f, c);
        @(negedge clk);
        bus_rd = 1; bus_addr = {4'h5, 2'b00};
        @(negedge clk);
        irq_raise = 1;
        @(negedge clk);
        irq_raise = 0;
        @(posedge clk); #1;
        check("R8 held read clears only once", 128'(irq_line), 128'(1));
        @(negedge clk);
        bus_rd = 0;
        rd_reg(4'h5, v, q);
        check("R8 fresh strobe clears", 128'(q), 128'(0));

        // R9: status set beats the count-write clear
        cycle(1'b1, 1'b0, 4'h0, '0, 8'h99, 1'b0, 7'h10, v, q, f, c);
        rd_reg(4'h4, v, q);
        check("R9 set wins over count write", 128'(v), 128'(8'h10));
        wr_reg(4'h1, 8'h01);
        rd_reg(4'h4, v, q);
        check("R5 count write clears bit 4", 128'(v), 128'(8'h00));

        // R1: low address bits ignored
        cycle(1'b0, 1'b1, 4'h8, 2'b11, 8'h00, 1'b0, 7'h00, v, q, f, c);
        check("R1 read with low bits set", 128'(v), 128'(8'h5A));
        cycle(1'b1, 1'b0, 4'hC, 2'b01, 8'h3C, 1'b0, 7'h00, v, q, f, c);
        rd_reg(4'hC, v, q);
        check("R1 write with low bits set", 128'(v), 128'(8'h3C));

        // R11: command strobe
        cycle(1'b1, 1'b0, 4'h3, '0, 8'h05, 1'b0, 7'h00, v, q, f, c);
        check("R11 cmd_fire on command write", 128'(f), 128'(1));
        check("R11 cmd_code", 128'(c), 128'(8'h05));
        cycle(1'b1, 1'b0, 4'h2, '0, 8'h66, 1'b0, 7'h00, v, q, f, c);
        check("R11 no cmd_fire elsewhere", 128'(f), 128'(0));

        // R3: write-only offset reaches the write bank
        wr_reg(4'h6, 8'h2E);
        check("R3 write bank offset 6", 128'(wr_regs[6*8 +: 8]), 128'(8'h2E));
        rd_reg(4'h6, v, q);
        check("R3 offset 6 not readable", 128'(v), 128'(8'h00));

        // R2: reset in the middle
        cycle(1'b0, 1'b0, 4'h0, '0, 8'h00, 1'b1, 7'h00, v, q, f, c);
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        check("R2 irq cleared by reset", 128'(irq_line), 128'(0));
        check("R2 write bank cleared", wr_regs, 128'(0));
        rd_reg(4'h8, v, q);
        check("R2 offset 8 reset value", 128'(v), 128'(8'h07));
        rd_reg(4'hE, v, q);
        check("R2 offset 14 reset value", 128'(v), 128'(8'h04));
        rd_reg(4'hC, v, q);
        check("R2 offset 12 cleared", 128'(v), 128'(8'h00));
        wr_reg(4'h3, 8'h80);
        rd_reg(4'h0, v, q);
        check("R4 reload after reset gives zero", 128'(v), 128'(8'h00));

        summary_and_end();
    end

endmodule